// File: doc/BRIEF.md
# Clocked Monostable Pulse Generator

This block produces a single clean pulse of programmable length on a rising edge of a trigger input. It rests with `q_out` low and `q_n_out` high. A trigger edge moves it into the active level. After the programmed number of clock cycles it returns to rest without further action.

The trigger first passes through a two-flop synchronizer. A rising-edge detector then turns each low-to-high change of the synchronized trigger into a one-cycle event. A two-state machine holds the pulse: `OS_IDLE` (rest) and `OS_ACTIVE` (pulse in progress). A remaining-cycle counter runs alongside it.

The transitions are:
- **start**: `OS_IDLE` to `OS_ACTIVE` on an event, which loads the counter.
- **reload**: `OS_ACTIVE` to `OS_ACTIVE` on an event in retriggerable mode, which reloads the counter.
- **ignore**: `OS_ACTIVE` to `OS_ACTIVE` on an event in non-retriggerable mode, which leaves the count running.
- **count**: `OS_ACTIVE` to `OS_ACTIVE` with no event and a nonzero count, which decrements the counter.
- **expire**: `OS_ACTIVE` to `OS_IDLE` when the count reaches zero and no reload occurs.

Synchronous reset forces `OS_IDLE` from any state.

Top module: `pulse_oneshot`

## Requirements
- R1: After synchronous reset `rst`=1, `q_out`=0 and `q_n_out`=1. The outputs stay there until a trigger event occurs.
- R2: A trigger event is a rising edge of `trig_in` after two synchronizing flops. If `trig_in` is first sampled high at rising clock edge E0, `q_out` rises at edge E2.
- R3: With a loaded length N, `q_out` stays high for exactly N clock cycles and then returns low by itself.
- R4: A trigger held high produces only one event. A further event needs `trig_in` to be sampled low at least once.
- R5: With `retrig_mode`=0 (non-retriggerable), an event during an active pulse is ignored. The pulse ends N cycles after the event that started it.
- R6: With `retrig_mode`=1 (retriggerable), an event during an active pulse reloads the count. `q_out` stays high until N cycles after the last event.
- R7: `retrig_mode` is used only at the moment of an event. Changing it mid-pulse affects only how later events are handled.
- R8: Asserting `rst` during a pulse forces `q_out` low at the next rising edge and clears the count.
- R9: A `pulse_len` of 0 is treated as 1. A length of 1 gives a single-cycle pulse.
- R10: `pulse_len` is captured only when an event starts or reloads a pulse. Changing it mid-pulse does not alter the running pulse.
- R11: `q_n_out` is always the inverse of `q_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Trigger, may be asynchronous |
| retrig_mode | input | 1 | 1 = retriggerable, 0 = non-retriggerable |
| pulse_len | input | CNT_W | Pulse length in clock cycles (0 acts as 1) |
| q_out | output | 1 | Pulse output, low at rest |
| q_n_out | output | 1 | Complement of q_out |

## Verification
The bench aims at the off-by-one edges of the pulse. It measures the exact latency from trigger to output and the exact width for lengths of 0, 1 and larger values. A design with a wrong counter load or end test gives a pulse one cycle too long or too short.

A second trigger arriving mid-pulse is checked in both modes. A block with the mode logic swapped would give 12 cycles where 8 are expected, or the reverse. Switching the mode between the start and the second trigger catches a block that reads the mode continuously instead of at each event.

A trigger held high for many cycles exposes a level-sensitive detector, which would stretch or repeat the pulse. A reset in mid-pulse catches a block that lets the count keep running, which would leave the output stuck high. A length change during a pulse catches a block that compares against the live input instead of the captured value.

// File: rtl/oneshot_pkg.sv
`timescale 1ns/1ps
package oneshot_pkg;
    typedef enum logic [0:0] {
        OS_IDLE   = 1'b0,
        OS_ACTIVE = 1'b1
    } os_state_e;
endpackage

// File: rtl/oneshot_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for an asynchronous single-bit input.
module oneshot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/oneshot_edge.sv
`timescale 1ns/1ps
// Rising-edge detector: one-cycle event per low-to-high change.
module oneshot_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic evt
);
    logic level_prev;

    always_ff @(posedge clk) begin
        if (rst) level_prev <= 1'b0;
        else     level_prev <= level;
    end

    assign evt = level & ~level_prev;
endmodule

// File: rtl/oneshot_ctrl.sv
`timescale 1ns/1ps
// Pulse state machine with remaining-cycle counter.
module oneshot_ctrl
    import oneshot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             retrig,
    input  logic [CNT_W-1:0] len,
    output logic             active,
    output logic [CNT_W-1:0] remain
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    os_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] load_val;

    // zero length behaves as one cycle
    assign load_val = (len == '0) ? '0 : (len - ONE);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: start, reload, ignore, count, expire
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            OS_IDLE: begin
                if (evt) begin
                    state_d = OS_ACTIVE;
                    cnt_d   = load_val;
                end
            end
            OS_ACTIVE: begin
                if (evt && retrig) begin
                    cnt_d = load_val;
                end else if (cnt_q == '0) begin
                    state_d = OS_IDLE;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            default: begin
                state_d = OS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // output decode
    always_comb begin
        active = (state_q == OS_ACTIVE);
        remain = cnt_q;
    end
endmodule

// File: rtl/pulse_oneshot.sv
`timescale 1ns/1ps
// Clocked monostable with run-time retrigger selection.
module pulse_oneshot #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_in,
    input  logic             retrig_mode,
    input  logic [CNT_W-1:0] pulse_len,
    output logic             q_out,
    output logic             q_n_out
);
    logic             trig_sync;
    logic             trig_evt;
    logic             pulse_on;
    logic [CNT_W-1:0] remain;

    oneshot_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (trig_in),
        .dout (trig_sync)
    );

    oneshot_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (trig_sync),
        .evt   (trig_evt)
    );

    oneshot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .evt    (trig_evt),
        .retrig (retrig_mode),
        .len    (pulse_len),
        .active (pulse_on),
        .remain (remain)
    );

    assign q_out   = pulse_on;
    assign q_n_out = ~pulse_on;
endmodule

// File: rtl/pulse_oneshot_chk.sv
`timescale 1ns/1ps
module pulse_oneshot_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             evt,
    input logic             mode,
    input logic [CNT_W-1:0] len,
    input logic             q,
    input logic             qn,
    input logic [CNT_W-1:0] remain
);
    AST_REST_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!q && qn)); // R1

    AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(q) |-> $past(evt)); // R2

    AST_EVENT_STARTS: assert property (@(posedge clk) disable iff (rst)
        (evt && !q) |=> q); // R2

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (q && !evt && remain != '0) |=> (q && remain == $past(remain) - CNT_W'(1))); // R3

    AST_EXPIRE: assert property (@(posedge clk) disable iff (rst)
        (q && !evt && remain == '0) |=> !q); // R3

    AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt); // R4

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
        (q && evt && !mode && remain != '0) |=> (q && remain == $past(remain) - CNT_W'(1))); // R5

    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (q && evt && mode && len != '0) |=> (q && remain == $past(len) - CNT_W'(1))); // R6

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        qn == !q); // R11
endmodule

bind pulse_oneshot pulse_oneshot_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .evt    (trig_evt),
    .mode   (retrig_mode),
    .len    (pulse_len),
    .q      (q_out),
    .qn     (q_n_out),
    .remain (remain)
);

// File: tb/pulse_oneshot_bench.sv
`timescale 1ns/1ps
module pulse_oneshot_bench;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trig_in = 1'b0;
    logic             retrig_mode = 1'b0;
    logic [CNT_W-1:0] pulse_len = '0;
    logic             q_out, q_n_out;

    int checks = 0;
    int errors = 0;
    int hi_cnt = 0;
    int rises  = 0;
    logic q_prev = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    pulse_oneshot #(.CNT_W(CNT_W)) u_pulse_oneshot (
        .clk         (clk),
        .rst         (rst),
        .trig_in     (trig_in),
        .retrig_mode (retrig_mode),
        .pulse_len   (pulse_len),
        .q_out       (q_out),
        .q_n_out     (q_n_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (q_out) hi_cnt++;
            if (q_out && !q_prev) rises++;
            checks++;
            if (q_n_out !== ~q_out) begin
                errors++;
                $display("FAIL R11: actual q_n=%0b expected=%0b", q_n_out, ~q_out);
            end
        end
        q_prev = q_out;
    end

    task automatic clear_counts();
        hi_cnt = 0;
        rises  = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic fire();
        @(negedge clk) trig_in = 1'b1;
        @(negedge clk) trig_in = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(3);
        chk("R1 q at reset", int'(q_out), 0);
        chk("R1 q_n at reset", int'(q_n_out), 1);
        rst = 1'b0;
        idle(10);
        chk("R1 q stays at rest", int'(q_out), 0);
    endtask

    task automatic t_latency_width();
        pulse_len = 16'd5; retrig_mode = 1'b0;
        clear_counts();
        @(negedge clk) trig_in = 1'b1;
        @(negedge clk);
        chk("R2 q after E0", int'(q_out), 0);
        trig_in = 1'b0;
        @(negedge clk);
        chk("R2 q after E1", int'(q_out), 0);
        @(negedge clk);
        chk("R2 q after E2", int'(q_out), 1);
        idle(12);
        chk("R3 width N=5", hi_cnt, 5);
        chk("R3 one pulse", rises, 1);
    endtask

    task automatic t_held();
        pulse_len = 16'd4; retrig_mode = 1'b1;
        clear_counts();
        @(negedge clk) trig_in = 1'b1;
        idle(30);
        trig_in = 1'b0;
        idle(8);
        chk("R4 held trigger width", hi_cnt, 4);
        chk("R4 held trigger pulses", rises, 1);
    endtask

    task automatic t_nonretrig();
        pulse_len = 16'd8; retrig_mode = 1'b0;
        clear_counts();
        fire();
        idle(2);
        fire();
        idle(20);
        chk("R5 non-retrig width", hi_cnt, 8);
        chk("R5 non-retrig pulses", rises, 1);
    endtask

    task automatic t_retrig();
        pulse_len = 16'd8; retrig_mode = 1'b1;
        clear_counts();
        fire();
        idle(2);
        fire();
        idle(24);
        chk("R6 retrig width", hi_cnt, 12);
        chk("R6 retrig pulses", rises, 1);
    endtask

    task automatic t_mode_change();
        pulse_len = 16'd8; retrig_mode = 1'b1;
        clear_counts();
        fire();
        retrig_mode = 1'b0;
        idle(2);
        fire();
        idle(20);
        chk("R7 mode switched mid-pulse", hi_cnt, 8);
        // reverse: start non-retrig, switch to retrig before second event
        retrig_mode = 1'b0;
        clear_counts();
        fire();
        retrig_mode = 1'b1;
        idle(2);
        fire();
        idle(24);
        chk("R7 mode switched to retrig", hi_cnt, 12);
    endtask

    task automatic t_reset_mid();
        pulse_len = 16'd10; retrig_mode = 1'b0;
        fire();
        idle(4);
        chk("R8 pulse running", int'(q_out), 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 q after reset edge", int'(q_out), 0);
        chk("R8 q_n after reset edge", int'(q_n_out), 1);
        idle(1);
        rst = 1'b0;
        clear_counts();
        idle(15);
        chk("R8 no pulse resumes", hi_cnt, 0);
    endtask

    task automatic t_short();
        retrig_mode = 1'b0;
        pulse_len = 16'd1;
        clear_counts();
        fire();
        idle(6);
        chk("R9 length one", hi_cnt, 1);
        pulse_len = 16'd0;
        clear_counts();
        fire();
        idle(6);
        chk("R9 length zero", hi_cnt, 1);
    endtask

    task automatic t_len_change();
        retrig_mode = 1'b0;
        pulse_len = 16'd6;
        clear_counts();
        fire();
        idle(2);
        pulse_len = 16'd2;
        idle(12);
        chk("R10 length captured", hi_cnt, 6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency_width();
        t_held();
        t_nonretrig();
        t_retrig();
        t_mode_change();
        t_reset_mid();
        t_short();
        t_len_change();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule